// File: doc/BRIEF.md
# Status Monitor Interrupt Unit

This unit watches twelve status lines coming back from a configurable logic fabric during and after a configuration load. It turns them into a single interrupt request. Each line first passes through a two-stage synchronizer. It is then qualified by its own trigger mode and polarity, and it sets a pending bit. A pending bit reaches the interrupt output only when it is enabled and unmasked. Software programs the unit and inspects it over a 32-bit word register port. Reads have no side effects, and writes take effect on the clock edge.

A pending bit in level mode follows the qualified input on every cycle. In edge mode the bit latches on the selected transition and stays set until software writes a 1 to the matching bit of the acknowledge register. Software reads the synchronized line values directly and decides for itself whether a configuration attempt succeeded. The twelve lines keep fixed positions: bit 0 is the active-low fault line, 1 load-done, 2 init-done, 3 checksum error, 4 alternate-path load done, 5 partial-update ready, 6 partial-update error, 7 partial-update done, 8 the configuration-request pin, 9 the fault pin, 10 the load-done pin and 11 fabric power good. The same bit positions apply in every register.

Top module: `monirq_unit`

## Requirements
- R1: After reset the enable (0x00), mask (0x04), trigger (0x08) and polarity (0x0C) registers read 0 and irq_o is low.
- R2: A read of 0x1C returns the synchronized input vector in bits 11:0, with input bit i at bit i and bits 31:12 zero. An input change is visible on the second rising clock edge after it is applied.
- R3: With trigger bit 0 (level), raw status bit i (0x14) equals the input when polarity bit i is 1 and the inverted input when it is 0. An acknowledge write does not change it.
- R4: With trigger bit 1 (edge), raw status bit i is set by a rising input edge when polarity is 1 and by a falling edge when polarity is 0. The opposite edge does not set it, and the bit then holds until acknowledged.
- R5: Writing the acknowledge register (0x18) clears every edge-mode raw bit written as 1 and leaves the bits written as 0 pending.
- R6: When a new edge and an acknowledge of the same bit arrive in the same cycle, the bit stays pending.
- R7: The masked status (0x10) equals raw AND enable AND NOT mask, so a mask bit of 1 hides that source.
- R8: irq_o is high exactly when some masked status bit is 1.
- R9: Writes to 0x10, 0x14 and 0x1C change no state. Configuration registers keep only bits 11:0, and reads of 0x18 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W | Byte address, word-aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| mon_i | input | NUM_MON | Asynchronous monitor lines |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The assertions take for granted that reset starts low at time zero. They also assume that edge detection sees at least one cycle of each input level after synchronization. The stimulus therefore holds every monitor value for several cycles, with one exception: the same-cycle acknowledge case. There the write is placed on the exact edge where the synchronized transition latches. Register accesses last one cycle, are aligned to word addresses, and never overlap an input change that the same check depends on.

// File: rtl/monirq_pkg.sv
package monirq_pkg;
   localparam int unsigned DATA_W   = 32;
   localparam int unsigned NUM_REGS = 8;
   localparam int unsigned CFG_REGS = 4;

   // Register word index: addr[..:2]
   typedef enum logic [2:0] {
      SEL_ENABLE = 3'd0,
      SEL_MASK   = 3'd1,
      SEL_TRIG   = 3'd2,
      SEL_POL    = 3'd3,
      SEL_STAT   = 3'd4,
      SEL_RAW    = 3'd5,
      SEL_ACK    = 3'd6,
      SEL_PORT   = 3'd7
   } reg_sel_e;

   // Fixed monitor line positions (shared by every register)
   localparam int unsigned MONB_FAULT_N    = 0;
   localparam int unsigned MONB_LOAD_DONE  = 1;
   localparam int unsigned MONB_INIT_DONE  = 2;
   localparam int unsigned MONB_CRC_ERR    = 3;
   localparam int unsigned MONB_ALT_DONE   = 4;
   localparam int unsigned MONB_PART_RDY   = 5;
   localparam int unsigned MONB_PART_ERR   = 6;
   localparam int unsigned MONB_PART_DONE  = 7;
   localparam int unsigned MONB_REQ_PIN    = 8;
   localparam int unsigned MONB_FAULT_PIN  = 9;
   localparam int unsigned MONB_DONE_PIN   = 10;
   localparam int unsigned MONB_POWER_OK   = 11;
endpackage

// File: rtl/monirq_sync.sv
module monirq_sync #(
   parameter int unsigned W      = 12,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   localparam int unsigned FILL_W = $clog2(STAGES + 1);

   if (STAGES < 2) begin : g_bad_stages
      $error("monirq_sync: STAGES must be at least 2");
   end

   logic [W-1:0]      stage_q [STAGES];
   logic [FILL_W-1:0] fill_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j < STAGES; j++) stage_q[j] <= '0;
      end else begin
         stage_q[0] <= d_i;
         for (int j = 1; j < STAGES; j++) stage_q[j] <= stage_q[j-1];
      end
   end

   assign q_o = stage_q[STAGES-1];

   // cycles since reset, saturating; lets the delay check start cleanly
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          fill_q <= '0;
      else if (fill_q != FILL_W'(STAGES))  fill_q <= fill_q + 1'b1;
   end

   assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_q == FILL_W'(STAGES)) |-> (q_o == $past(d_i, STAGES)));
endmodule

// File: rtl/monirq_detect.sv
module monirq_detect #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] mon_s_i,
   input  logic [W-1:0] trig_i,
   input  logic [W-1:0] pol_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] raw_o
);
   logic [W-1:0] prev_q;
   logic [W-1:0] active;
   logic [W-1:0] prev_active;
   logic [W-1:0] set_edge;
   logic [W-1:0] raw_q;
   logic [W-1:0] raw_nxt;

   // polarity 1: high is active; polarity 0: low is active
   assign active      = ~(mon_s_i ^ pol_i);
   assign prev_active = ~(prev_q  ^ pol_i);

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign set_edge[i] = trig_i[i] & active[i] & ~prev_active[i];

      assert_edge_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (trig_i[i] && raw_q[i] && !clr_i[i]) |=> raw_q[i]);

      assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (trig_i[i] && clr_i[i] && !set_edge[i]) |=> !raw_q[i]);

      assert_edge_beats_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
         set_edge[i] |=> raw_q[i]);
   end

   assign raw_nxt = (trig_i & (set_edge | (raw_q & ~clr_i)))
                  | (~trig_i & active);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         raw_q  <= '0;
      end else begin
         prev_q <= mon_s_i;
         raw_q  <= raw_nxt;
      end
   end

   assign raw_o = raw_q;
endmodule

// File: rtl/monirq_regs.sv
module monirq_regs
   import monirq_pkg::*;
#(
   parameter int unsigned W      = 12,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [W-1:0]      raw_i,
   input  logic [W-1:0]      port_i,
   output logic [W-1:0]      en_o,
   output logic [W-1:0]      mask_o,
   output logic [W-1:0]      trig_o,
   output logic [W-1:0]      pol_o,
   output logic [W-1:0]      clr_o,
   output logic [W-1:0]      masked_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int unsigned IDX_W = ADDR_W - 2;

   if (ADDR_W < 5 || ADDR_W > 16) begin : g_bad_addr
      $error("monirq_regs: ADDR_W must be within 5..16");
   end

   logic [IDX_W-1:0]                idx;
   logic                            hit;
   reg_sel_e                        sel;
   logic [CFG_REGS-1:0][W-1:0]      cfg_q;

   assign idx = addr[ADDR_W-1:2];
   assign hit = (int'(idx) < NUM_REGS);
   assign sel = reg_sel_e'(idx[2:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else begin
         for (int k = 0; k < CFG_REGS; k++) begin
            if (wr_en && hit && (idx[2:0] == 3'(k))) cfg_q[k] <= wdata[W-1:0];
         end
      end
   end

   assign en_o   = cfg_q[SEL_ENABLE];
   assign mask_o = cfg_q[SEL_MASK];
   assign trig_o = cfg_q[SEL_TRIG];
   assign pol_o  = cfg_q[SEL_POL];

   assign clr_o    = (wr_en && hit && sel == SEL_ACK) ? wdata[W-1:0] : '0;
   assign masked_o = raw_i & en_o & ~mask_o;

   always_comb begin
      rdata_o = '0;
      if (hit) begin
         case (sel)
            SEL_ENABLE: rdata_o[W-1:0] = en_o;
            SEL_MASK:   rdata_o[W-1:0] = mask_o;
            SEL_TRIG:   rdata_o[W-1:0] = trig_o;
            SEL_POL:    rdata_o[W-1:0] = pol_o;
            SEL_STAT:   rdata_o[W-1:0] = masked_o;
            SEL_RAW:    rdata_o[W-1:0] = raw_i;
            SEL_PORT:   rdata_o[W-1:0] = port_i;
            default:    rdata_o = '0;
         endcase
      end
   end

   assert_ro_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (!hit || sel >= SEL_STAT)) |=> $stable(cfg_q));
endmodule

// File: rtl/monirq_unit.sv
module monirq_unit
   import monirq_pkg::*;
#(
   parameter int unsigned NUM_MON     = 12,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   input  logic [NUM_MON-1:0] mon_i,
   output logic               irq_o
);
   if (NUM_MON < 1 || NUM_MON > DATA_W) begin : g_bad_width
      $error("monirq_unit: NUM_MON must be within 1..DATA_W");
   end

   logic [NUM_MON-1:0] mon_s;
   logic [NUM_MON-1:0] raw;
   logic [NUM_MON-1:0] en;
   logic [NUM_MON-1:0] mask;
   logic [NUM_MON-1:0] trig;
   logic [NUM_MON-1:0] pol;
   logic [NUM_MON-1:0] clr;
   logic [NUM_MON-1:0] masked;

   monirq_sync #(.W(NUM_MON), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (mon_i),
      .q_o   (mon_s)
   );

   monirq_detect #(.W(NUM_MON)) u_detect (
      .clk     (clk),
      .rst_n   (rst_n),
      .mon_s_i (mon_s),
      .trig_i  (trig),
      .pol_i   (pol),
      .clr_i   (clr),
      .raw_o   (raw)
   );

   monirq_regs #(.W(NUM_MON), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .raw_i    (raw),
      .port_i   (mon_s),
      .en_o     (en),
      .mask_o   (mask),
      .trig_o   (trig),
      .pol_o    (pol),
      .clr_o    (clr),
      .masked_o (masked),
      .rdata_o  (rdata)
   );

   assign irq_o = |masked;

   assert_irq_has_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((raw & en) != '0));

   assert_irq_quiet_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq_o);
endmodule

// File: tb/monirq_unit_tb.sv
`timescale 1ns/1ps
module monirq_unit_tb;
   localparam logic [4:0] A_EN   = 5'h00;
   localparam logic [4:0] A_MSK  = 5'h04;
   localparam logic [4:0] A_TRG  = 5'h08;
   localparam logic [4:0] A_POL  = 5'h0C;
   localparam logic [4:0] A_STAT = 5'h10;
   localparam logic [4:0] A_RAW  = 5'h14;
   localparam logic [4:0] A_ACK  = 5'h18;
   localparam logic [4:0] A_PORT = 5'h1C;

   logic        clk   = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  addr  = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [11:0] mon   = '0;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb_q[$];

   always #4 clk = ~clk;

   monirq_unit u_dut (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata),
      .mon_i (mon),
      .irq_o (irq)
   );

   // monitor: compare after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {31'b0, irq} : rdata;
            n_checks++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_now(input logic [4:0] a, input logic [31:0] e, input string tag);
      item_t it;
      addr = a;
      it.is_irq = 1'b0; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      rd_now(a, e, tag);
   endtask

   task automatic chk_irq(input bit e, input string tag);
      item_t it;
      @(negedge clk);
      it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
      sb_q.push_back(it);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset values
      rd(A_EN,  32'h0, "R1 enable");
      rd(A_MSK, 32'h0, "R1 mask");
      rd(A_TRG, 32'h0, "R1 trigger");
      rd(A_POL, 32'h0, "R1 polarity");
      chk_irq(1'b0, "R1 irq");

      // R2 port readback and two-edge latency
      mon = 12'hA5C;
      idle(4);
      rd(A_PORT, 32'h0000_0A5C, "R2 port value");
      @(negedge clk);
      mon = 12'h3F0;
      rd_now(A_PORT, 32'h0000_0A5C, "R2 one edge still old");
      rd(A_PORT, 32'h0000_03F0, "R2 second edge new");

      // R3 level mode, both polarities
      wr(A_EN,  32'hFFF);
      wr(A_POL, 32'hFFF);
      idle(4);
      rd(A_RAW,  32'h3F0, "R3 level active high");
      rd(A_STAT, 32'h3F0, "R7 masked all enabled");
      chk_irq(1'b1, "R8 irq on pending");
      wr(A_POL, 32'h000);
      idle(4);
      rd(A_RAW, 32'hC0F, "R3 level active low");
      wr(A_ACK, 32'hFFF);
      idle(2);
      rd(A_RAW, 32'hC0F, "R3 ack ignored on level");

      // R7 masking and enable
      wr(A_MSK, 32'h00F);
      rd(A_STAT, 32'hC00, "R7 mask hides low nibble");
      chk_irq(1'b1, "R8 irq from unmasked");
      wr(A_EN, 32'h00F);
      rd(A_STAT, 32'h000, "R7 disabled and masked");
      chk_irq(1'b0, "R8 irq low when none");
      wr(A_EN,  32'hFFF);
      wr(A_MSK, 32'h000);

      // R4 edge mode, rising
      mon = 12'h000;
      idle(4);
      wr(A_POL, 32'hFFF);
      wr(A_TRG, 32'hFFF);
      wr(A_ACK, 32'hFFF);
      idle(3);
      rd(A_RAW, 32'h000, "R4 edge baseline");
      chk_irq(1'b0, "R8 baseline irq");
      mon = 12'h005;
      idle(4);
      rd(A_RAW, 32'h005, "R4 rising latched");
      chk_irq(1'b1, "R8 edge irq");
      mon = 12'h000;
      idle(4);
      rd(A_RAW, 32'h005, "R4 held after falling");
      wr(A_ACK, 32'h001);
      rd(A_RAW, 32'h004, "R5 partial ack");
      wr(A_ACK, 32'h004);
      rd(A_RAW, 32'h000, "R5 full ack");
      chk_irq(1'b0, "R8 irq cleared");

      // R4 falling edges with polarity 0
      wr(A_POL, 32'h000);
      idle(2);
      rd(A_RAW, 32'h000, "R4 polarity change no edge");
      mon = 12'h0C0;
      idle(4);
      rd(A_RAW, 32'h000, "R4 rising ignored when low active");
      mon = 12'h000;
      idle(4);
      rd(A_RAW,  32'h0C0, "R4 falling latched");
      rd(A_STAT, 32'h0C0, "R7 edge masked status");

      // R6 edge and ack in the same cycle
      wr(A_ACK, 32'h0C0);
      rd(A_RAW, 32'h000, "R5 ack both");
      mon = 12'h040;
      idle(4);
      rd(A_RAW, 32'h000, "R4 inactive transition");
      @(negedge clk);
      mon = 12'h000;
      @(negedge clk);
      wr(A_ACK, 32'h040);
      rd(A_RAW, 32'h040, "R6 new edge survives ack");
      wr(A_ACK, 32'h040);
      rd(A_RAW, 32'h000, "R5 later ack clears");

      // R9 read-only writes and field widths
      wr(A_RAW,  32'hFFF);
      wr(A_STAT, 32'hFFF);
      wr(A_PORT, 32'hFFF);
      rd(A_EN,   32'h0000_0FFF, "R9 enable unchanged");
      rd(A_MSK,  32'h0000_0000, "R9 mask unchanged");
      rd(A_TRG,  32'h0000_0FFF, "R9 trigger unchanged");
      rd(A_POL,  32'h0000_0000, "R9 polarity unchanged");
      rd(A_RAW,  32'h0000_0000, "R9 raw unchanged");
      rd(A_PORT, 32'h0000_0000, "R9 port unchanged");
      wr(A_EN, 32'hFFFF_FFFF);
      rd(A_EN,  32'h0000_0FFF, "R9 upper bits dropped");
      rd(A_ACK, 32'h0000_0000, "R9 ack reads zero");

      idle(3);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule